// File: doc/BRIEF.md
# Transmit Holding Buffer Controller

This block sits between a bus write port and the transmit shift register of one serial channel. It keeps one character in a holding register and reports through a ready flag whether that register can take a new character. When the shifter reports empty and a character is waiting, the block issues a one-cycle load pulse that hands the character over. In the same clock edge it raises the ready flag again, so software can write the next character while the previous one is still being shifted out.

Writes are gated. A write is dropped without effect if the ready flag is low, if the channel transmitter is disabled, or if the serial module is stopped. The block does no framing, no baud timing and no serialization; the shifter is an external partner that takes the load pulse and drives the empty flag.

Top module: `tx_hold_ctrl`

## Requirements
- R1: After reset, `tx_rdy_o` is 1, `ld_data_o` is all zeros and `ld_o` is 0.
- R2: A write is accepted when `wr_en_i`=1, `tx_rdy_o`=1, `tx_en_i`=1 and `mod_stop_i`=0. At the next clock edge the character appears on `ld_data_o` and `tx_rdy_o` drops to 0.
- R3: A write that arrives while `tx_rdy_o`=0 leaves the held character unchanged.
- R4: A write that arrives while `tx_en_i`=0 leaves the held character unchanged and `tx_rdy_o` at 1.
- R5: A write that arrives while `mod_stop_i`=1 leaves the held character unchanged and `tx_rdy_o` at 1.
- R6: `ld_o` is 1 exactly when `tx_rdy_o`=0 and `sh_empty_i`=1. While `ld_o` is 1, `ld_data_o` carries the held character, and the pulse lasts one cycle.
- R7: `tx_rdy_o` returns to 1 at the clock edge on which `ld_o` is 1. It does not wait for the shifter to finish.
- R8: An accepted write and a load never fall in the same cycle. While `sh_empty_i`=0, a held character stays held and `tx_rdy_o` stays 0.
- R9: A character that is already held is still handed to the shifter after `tx_en_i` falls or `mod_stop_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe for the holding register |
| wr_data_i | input | DATA_W | Character to write |
| tx_en_i | input | 1 | Channel transmitter enable |
| mod_stop_i | input | 1 | Serial module stop; 1 blocks writes |
| tx_rdy_o | output | 1 | Transmitter ready: holding register is free |
| sh_empty_i | input | 1 | Shift register empty, driven by the shifter |
| ld_o | output | 1 | One-cycle load pulse to the shifter |
| ld_data_o | output | DATA_W | Held character; the shifter takes it when ld_o is 1 |

## Verification
Two events can meet in one cycle: a bus write and the hand-off of the held character. Both become possible when the shifter goes empty while a character is waiting. The bench drives a write strobe in exactly the cycle where the load pulse is high. It then checks that the shifter stub captures the old character, that the new write is dropped, and that the ready flag rises at that edge. Every character value from 0 to 255 is also sent through the path that has no wait, so that value is loaded on the cycle right after the write.

// File: rtl/tx_hold_pkg.sv
package tx_hold_pkg;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/tx_hold_gate.sv
module tx_hold_gate (
  input  logic wr_en_i,
  input  logic rdy_i,
  input  logic tx_en_i,
  input  logic mod_stop_i,
  output logic acc_o
);
  assign acc_o = wr_en_i & rdy_i & tx_en_i & ~mod_stop_i;
endmodule

// File: rtl/tx_hold_store.sv
module tx_hold_store #(
  parameter int unsigned DATA_W = tx_hold_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] hold_o
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (acc_i) hold_q <= wr_data_i;
  end

  assign hold_o = hold_q;

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> hold_q == $past(wr_data_i));

  // R3
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(hold_q));
endmodule

// File: rtl/tx_hold_flag.sv
module tx_hold_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic sh_empty_i,
  output logic rdy_o,
  output logic ld_o
);
  logic rdy_q;

  // a held character exists exactly while ready is low
  assign ld_o = ~rdy_q & sh_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdy_q <= 1'b1;
    else if (acc_i) rdy_q <= 1'b0;
    else if (ld_o)  rdy_q <= 1'b1;
  end

  assign rdy_o = rdy_q;

  // R2
  acc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !rdy_q);

  // R7
  ld_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> rdy_q);

  // R6
  ld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> !ld_o);

  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> !ld_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_q && !sh_empty_i) |=> !rdy_q);
endmodule

// File: rtl/tx_hold_ctrl.sv
module tx_hold_ctrl #(
  parameter int unsigned DATA_W = tx_hold_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              mod_stop_i,
  output logic              tx_rdy_o,
  input  logic              sh_empty_i,
  output logic              ld_o,
  output logic [DATA_W-1:0] ld_data_o
);
  logic acc;
  logic rdy;

  tx_hold_gate u_gate (
    .wr_en_i    (wr_en_i),
    .rdy_i      (rdy),
    .tx_en_i    (tx_en_i),
    .mod_stop_i (mod_stop_i),
    .acc_o      (acc)
  );

  tx_hold_store #(.DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .wr_data_i (wr_data_i),
    .hold_o    (ld_data_o)
  );

  tx_hold_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .sh_empty_i (sh_empty_i),
    .rdy_o      (rdy),
    .ld_o       (ld_o)
  );

  assign tx_rdy_o = rdy;

  // R4
  dis_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !tx_en_i) |=> $stable(ld_data_o));

  // R5
  stop_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mod_stop_i) |=> $stable(ld_data_o));

  // R3
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !tx_rdy_o) |=> $stable(ld_data_o));

  // R6
  ld_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |-> (!tx_rdy_o && sh_empty_i));
endmodule

// File: tb/sim_tx_hold_ctrl.sv
module sim_tx_hold_ctrl;
  localparam int CLK_T  = 10;
  localparam int DW     = 8;
  localparam int SH_LEN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic tx_en = 1'b1;
  logic stop = 1'b0;
  logic rdy, ld, sh_empty;
  logic [DW-1:0] ld_data;

  int errors = 0;
  int checks = 0;

  // shifter stub
  int cnt = 0;
  logic [DW-1:0] got = '0;
  assign sh_empty = (cnt == 0);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; got <= '0;
    end else if (ld) begin
      cnt <= SH_LEN; got <= ld_data;
    end else if (cnt != 0) cnt <= cnt - 1;
  end

  always #(CLK_T/2) clk = ~clk;

  tx_hold_ctrl #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_i(tx_en), .mod_stop_i(stop), .tx_rdy_o(rdy),
    .sh_empty_i(sh_empty), .ld_o(ld), .ld_data_o(ld_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a write for one cycle; returns at the negedge after the edge
  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_empty();
    while (!sh_empty) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1
    chk("R1 rdy", rdy, 1); chk("R1 data", ld_data, 0); chk("R1 ld", ld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy after release", rdy, 1);

    // R4 R5: sweep enable and stop with ready high and shifter idle
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 2; s++) begin
        logic [DW-1:0] prev, d;
        prev = ld_data;
        d = 8'h30 + 8'(e*2 + s);
        tx_en = e[0]; stop = s[0];
        wr(d);
        if (e == 1 && s == 0) begin
          chk("R2 data", ld_data, d); chk("R2 rdy", rdy, 0);
          chk("R6 ld", ld, 1);
          @(negedge clk);
          chk("R7 rdy", rdy, 1); chk("R6 ld one cycle", ld, 0);
          chk("R6 shifter got", got, d);
          wait_empty();
        end else begin
          chk(s ? "R5 data" : "R4 data", ld_data, prev);
          chk(s ? "R5 rdy" : "R4 rdy", rdy, 1);
          chk(s ? "R5 ld" : "R4 ld", ld, 0);
        end
      end
    end
    tx_en = 1'b1; stop = 1'b0;

    // R2 R6 R7: every character through the direct path
    for (int d = 0; d < 256; d++) begin
      wr(8'(d));
      if (ld_data != 8'(d) || rdy != 1'b0 || ld != 1'b1)
        chk("R2 sweep", ld_data, d);
      @(negedge clk);
      if (got != 8'(d) || rdy != 1'b1) chk("R7 sweep", got, d);
      wait_empty();
    end
    chk("R2 sweep done", got, 255);

    // R8 R3: write while shifter busy, then overrun attempt
    wr(8'hA5);
    @(negedge clk);
    chk("R7 rdy up while shifting", rdy, 1);
    chk("R8 busy", sh_empty, 0);
    wr(8'h5A);
    chk("R8 held rdy", rdy, 0); chk("R8 no ld while busy", ld, 0);
    wr(8'hC3);
    chk("R3 dropped", ld_data, 8'h5A);
    while (!ld) begin
      if (rdy) chk("R8 rdy stays low", rdy, 0);
      @(negedge clk);
    end
    // collision: write in the load cycle
    wr(8'h77);
    chk("R8 collision got", got, 8'h5A);
    chk("R8 collision data", ld_data, 8'h5A);
    chk("R7 collision rdy", rdy, 1);
    wait_empty();

    // R9: hand-off proceeds after disable and stop
    wr(8'h11);
    @(negedge clk);
    wr(8'h22);
    tx_en = 1'b0; stop = 1'b1;
    wait_empty();
    chk("R9 ld despite disable", ld, 1);
    @(negedge clk);
    chk("R9 got", got, 8'h22); chk("R9 rdy", rdy, 1);
    wr(8'h33);
    chk("R5 drop after stop", ld_data, 8'h22);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule